// File: doc/BRIEF.md
# Page Table Refill Engine

The engine loads a rectangular region of a page-address lookup table from a chain of descriptors held in memory. Software writes the address of the first descriptor into the pointer register while the engine reports READY. The engine then fetches each descriptor header, checks it, and streams one 32-bit page address per table entry from the data block the descriptor points at. Entries are written row by row across the rectangle. A descriptor whose next pointer is zero ends the chain, and the engine then raises a completion interrupt.

The register side is a single-cycle write strobe with a combinational read mux. The memory side issues one read at a time and accepts the reply any number of cycles later. The table side emits one write per cycle at most: an entry index, a data word and a table select. Writing zero to the pointer register returns the engine to idle at any time. A reply still outstanding at that moment is quietly discarded when it arrives.

Top module: `pt_refill_engine`

## Requirements
- R1: After reset the status register (address 1) reads 0x1 (only READY), the interrupt status (address 2) and enable (address 3) read 0, irq is low and no memory read is requested.
- R2: Writing 0 to the pointer register (address 0) sets READY (status bit 0) and clears VALID (bit 1), DONE (bit 2) and ERR (bit 3). During a walk, that write stops it: no further table writes occur and no completion interrupt is raised.
- R3: A nonzero write to the pointer register starts a walk only while READY is set. Otherwise it is ignored: no memory read is issued and the status is unchanged.
- R4: A descriptor is four words, read one at a time in this order: next pointer at +0; corners at +4 as {y1[31:24], x1[23:16], y0[15:8], x0[7:0]}; control at +8, with bit 0 as the start flag and bits 7:4 as the table select; data pointer at +12.
- R5: A valid descriptor produces exactly (x1-x0+1)*(y1-y0+1) table writes. They come in raster order with x increasing first, use index y*256+x, and take their data from consecutive words starting at the data pointer.
- R6: A nonzero next pointer makes the engine fetch that descriptor after the current one ends. A zero next pointer makes the current descriptor the last one.
- R7: When a chain ends without fault, the status reads 0x7 (READY, VALID and DONE) and interrupt status bit 7 (last-descriptor) is set.
- R8: A descriptor with the start flag clear sets ERR and interrupt status bit 1. It produces no table writes and ends the walk with READY clear.
- R9: A descriptor with x1<x0, y1<y0 or y1>=128 sets ERR and interrupt status bit 2. It produces no table writes and ends the walk.
- R10: Writing to the interrupt status register clears exactly the bits that are 1 in the written value.
- R11: Writes to address 3 set enable bits and writes to address 4 clear them. Both addresses read back the enable. irq is high whenever a set interrupt status bit has its enable set.
- R12: lut_sel carries the table select of the descriptor whose entries are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 pointer, 1 status, 2 interrupt status, 3 enable set, 4 enable clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read reply valid |
| mem_rdata | input | 32 | Read reply data |
| lut_we | output | 1 | Table entry write |
| lut_idx | output | COL_W+ROW_W | Table entry index |
| lut_data | output | 32 | Page address written to the entry |
| lut_sel | output | SEL_W | Table select from the descriptor |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that memory answers each request with exactly one reply, after any delay, and never sends a reply that was not asked for. They also assume that descriptors sit on 16-byte boundaries, so the four header words never straddle one. The bench memory keeps at most one request pending and rotates its reply delay between zero and two extra cycles. It only answers addresses the engine asked for, and it places every descriptor and data block on a 16-byte boundary. An abort is issued while a read is likely in flight, so that the discard path for a late reply is exercised.

// File: rtl/pt_refill_engine.sv
module pt_refill_engine #(
  parameter int AW    = 32,
  parameter int COL_W = 8,
  parameter int ROW_W = 7,
  parameter int SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [2:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   mem_req,
  output logic [AW-1:0]          mem_addr,
  input  logic                   mem_rvalid,
  input  logic [31:0]            mem_rdata,
  output logic                   lut_we,
  output logic [COL_W+ROW_W-1:0] lut_idx,
  output logic [31:0]            lut_data,
  output logic [SEL_W-1:0]       lut_sel,
  output logic                   irq
);
  localparam logic [2:0] A_PTR = 3'd0, A_STAT = 3'd1, A_IRQ = 3'd2, A_ENS = 3'd3, A_ENC = 3'd4;
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_CHK, S_DATA} st_t;

  st_t state;
  logic [AW-1:0] ptr, nxt, dptr;
  logic [31:0] area;
  logic start_b;
  logic [SEL_W-1:0] sel;
  logic [1:0] widx;
  logic [7:0] cx, cy;
  logic rd_busy, stale;
  logic s_ready, s_valid, s_done, s_err;
  logic [7:0] irq_raw, irq_en, irq_set;

  wire [7:0] x0 = area[7:0];
  wire [7:0] y0 = area[15:8];
  wire [7:0] x1 = area[23:16];
  wire [7:0] y1 = area[31:24];

  wire wr_ptr   = reg_we && reg_addr == A_PTR;
  wire abort    = wr_ptr && reg_wdata == 32'd0;
  wire arm      = wr_ptr && reg_wdata != 32'd0 && s_ready;
  wire rsp      = mem_rvalid && rd_busy && !stale;
  wire last_x   = cx == x1;
  wire last_y   = cy == y1;
  wire bad_rect = (x1 < x0) || (y1 < y0) || ((x1 >> COL_W) != 8'd0) || ((y1 >> ROW_W) != 8'd0);
  wire fin      = state == S_DATA && rsp && last_x && last_y && nxt == '0;

  assign irq_set  = abort ? 8'h00 :
                    {fin, 4'b0000, state == S_CHK && start_b && bad_rect, state == S_CHK && !start_b, 1'b0};
  assign mem_req  = !rd_busy && (state == S_HDR || state == S_DATA);
  assign mem_addr = (state == S_HDR) ? ptr + {{(AW-4){1'b0}}, widx, 2'b00} : dptr;
  assign lut_we   = rsp && state == S_DATA;
  assign lut_idx  = {cy[ROW_W-1:0], cx[COL_W-1:0]};
  assign lut_data = mem_rdata;
  assign lut_sel  = sel;
  assign irq      = |(irq_raw & irq_en);

  always_comb begin
    case (reg_addr)
      A_PTR:        reg_rdata = 32'(ptr);
      A_STAT:       reg_rdata = {28'd0, s_err, s_done, s_valid, s_ready};
      A_IRQ:        reg_rdata = {24'd0, irq_raw};
      A_ENS, A_ENC: reg_rdata = {24'd0, irq_en};
      default:      reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      stale   <= 1'b0;
      irq_raw <= 8'h00;
      irq_en  <= 8'h00;
    end else begin
      if (mem_req) rd_busy <= 1'b1;
      else if (mem_rvalid) rd_busy <= 1'b0;
      if (abort) stale <= mem_req || (rd_busy && !mem_rvalid);
      else if (stale && mem_rvalid) stale <= 1'b0;
      irq_raw <= (irq_raw & ~((reg_we && reg_addr == A_IRQ) ? reg_wdata[7:0] : 8'h00)) | irq_set;
      if (reg_we && reg_addr == A_ENS) irq_en <= irq_en | reg_wdata[7:0];
      else if (reg_we && reg_addr == A_ENC) irq_en <= irq_en & ~reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      nxt     <= '0;
      dptr    <= '0;
      area    <= 32'd0;
      start_b <= 1'b0;
      sel     <= '0;
      widx    <= 2'd0;
      cx      <= 8'd0;
      cy      <= 8'd0;
      s_ready <= 1'b1;
      s_valid <= 1'b0;
      s_done  <= 1'b0;
      s_err   <= 1'b0;
    end else if (abort) begin
      state   <= S_IDLE;
      s_ready <= 1'b1;
      s_valid <= 1'b0;
      s_done  <= 1'b0;
      s_err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (arm) begin
          ptr     <= reg_wdata[AW-1:0];
          widx    <= 2'd0;
          state   <= S_HDR;
          s_ready <= 1'b0;
          s_valid <= 1'b0;
          s_done  <= 1'b0;
          s_err   <= 1'b0;
        end
        S_HDR: if (rsp) begin
          case (widx)
            2'd0: nxt <= mem_rdata[AW-1:0];
            2'd1: area <= mem_rdata;
            2'd2: begin start_b <= mem_rdata[0]; sel <= mem_rdata[4 +: SEL_W]; end
            default: dptr <= mem_rdata[AW-1:0];
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) state <= S_CHK;
        end
        S_CHK: begin
          if (!start_b || bad_rect) begin
            s_err <= 1'b1;
            state <= S_IDLE;
          end else begin
            cx    <= x0;
            cy    <= y0;
            state <= S_DATA;
          end
        end
        S_DATA: if (rsp) begin
          dptr <= dptr + AW'(4);
          if (!last_x) cx <= cx + 8'd1;
          else begin
            cx <= x0;
            if (!last_y) cy <= cy + 8'd1;
            else if (nxt == '0) begin
              s_ready <= 1'b1;
              s_valid <= 1'b1;
              s_done  <= 1'b1;
              state   <= S_IDLE;
            end else begin
              ptr   <= nxt;
              widx  <= 2'd0;
              state <= S_HDR;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> state == S_IDLE);
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r5_write_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> (cx >= x0 && cx <= x1 && cy >= y0 && cy <= y1));
  a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_done) |-> (s_ready && s_valid && !s_err && irq_raw[7]));
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s_err |-> (!mem_req && !lut_we));
  a_r10_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_IRQ && reg_wdata[7] && !irq_set[7]) |=> !irq_raw[7]);
endmodule

// File: tb/tb_pt_refill_engine.sv
module tb_pt_refill_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic lut_we;
  logic [14:0] lut_idx;
  logic [31:0] lut_data;
  logic [3:0] lut_sel;
  logic irq;

  pt_refill_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lut_we(lut_we), .lut_idx(lut_idx), .lut_data(lut_data),
    .lut_sel(lut_sel), .irq(irq)
  );

  logic [31:0] mem [int];
  int exp_idx[$];
  logic [31:0] exp_dat[$];
  int exp_sel[$];
  int n_chk = 0, n_fail = 0, wr_seen = 0, nreq = 0, pend = -1;
  logic [31:0] paddr;
  int e_i, e_s;
  logic [31:0] e_d;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend == 0) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem.exists(int'(paddr)) ? mem[int'(paddr)] : 32'hDEAD0000;
      pend = -1;
    end else if (pend > 0) pend--;
    if (mem_req && rst_n) begin
      paddr = mem_addr;
      pend  = nreq % 3;
      nreq++;
    end
    #1;
    if (lut_we) begin
      if (exp_idx.size() == 0) chk(1'b0, "R5 unexpected table write", 32'(lut_idx), 32'hFFFFFFFF);
      else begin
        e_i = exp_idx.pop_front();
        e_d = exp_dat.pop_front();
        e_s = exp_sel.pop_front();
        chk(int'(lut_idx) == e_i, "R5 entry index", 32'(lut_idx), e_i);
        chk(lut_data == e_d, "R5 entry data", lut_data, e_d);
        chk(int'(lut_sel) == e_s, "R12 table select", 32'(lut_sel), e_s);
        wr_seen++;
      end
    end
  end

  task automatic add_desc(input int a, input int nx, input int x0, input int y0, input int x1,
                          input int y1, input int st, input int sl, input int dp, input bit push);
    int k = 0;
    mem[a]      = nx;
    mem[a + 4]  = {8'(y1), 8'(x1), 8'(y0), 8'(x0)};
    mem[a + 8]  = (sl << 4) | st;
    mem[a + 12] = dp;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        logic [31:0] d = (32'(dp) << 8) ^ 32'(k) ^ 32'hC0DE0000;
        mem[dp + 4 * k] = d;
        if (push) begin
          exp_idx.push_back(y * 256 + x);
          exp_dat.push_back(d);
          exp_sel.push_back(sl);
        end
        k++;
      end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_end(input string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (s[0] || s[3]) return;
    end
    chk(1'b0, req, s, 32'h1);
  endtask

  logic [31:0] v;
  int n0, ws0;

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, v); chk(v == 32'h1, "R1 status after reset", v, 32'h1);
    rd(3'd2, v); chk(v == 32'h0, "R1 irq status after reset", v, 32'h0);
    rd(3'd3, v); chk(v == 32'h0, "R1 enable after reset", v, 32'h0);
    chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq and request idle", {30'd0, irq, mem_req}, 32'd0);

    // R4 R5 R7 R12 single descriptor
    add_desc(32'h100, 0, 5, 10, 7, 11, 1, 3, 32'h2000, 1'b1);
    wr(3'd0, 32'h100);
    wait_end("R7 single descriptor finish");
    rd(3'd1, v); chk(v == 32'h7, "R7 status after chain", v, 32'h7);
    rd(3'd2, v); chk(v == 32'h80, "R7 last-descriptor interrupt", v, 32'h80);
    chk(exp_idx.size() == 0, "R4 R5 all entries written", exp_idx.size(), 0);

    // R10 R11 interrupt masking and clearing
    chk(irq == 1'b0, "R11 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h80);
    chk(irq == 1'b1, "R11 irq enabled", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h01);
    rd(3'd2, v); chk(v == 32'h80, "R10 unrelated bit write", v, 32'h80);
    wr(3'd4, 32'h80);
    chk(irq == 1'b0, "R11 enable cleared", {31'd0, irq}, 32'd0);
    rd(3'd4, v); chk(v == 32'h0, "R11 enable readback", v, 32'h0);
    wr(3'd3, 32'h80);
    wr(3'd2, 32'h80);
    rd(3'd2, v); chk(v == 32'h0, "R10 bit cleared", v, 32'h0);
    chk(irq == 1'b0, "R11 irq after clear", {31'd0, irq}, 32'd0);

    // R2 R6 chain of three descriptors
    wr(3'd0, 32'h0);
    rd(3'd1, v); chk(v == 32'h1, "R2 idle write", v, 32'h1);
    add_desc(32'h200, 32'h210, 250, 0, 255, 0, 1, 1, 32'h3000, 1'b1);
    add_desc(32'h210, 32'h220, 0, 127, 0, 127, 1, 2, 32'h3100, 1'b1);
    add_desc(32'h220, 0, 100, 50, 101, 52, 1, 15, 32'h3200, 1'b1);
    wr(3'd0, 32'h200);
    wait_end("R6 chain finish");
    rd(3'd1, v); chk(v == 32'h7, "R6 chain status", v, 32'h7);
    chk(exp_idx.size() == 0, "R6 chain entries", exp_idx.size(), 0);
    chk(irq == 1'b1, "R11 irq on completion", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'hFF);

    // R3 arm straight after completion (READY set)
    add_desc(32'h300, 0, 20, 3, 23, 3, 1, 5, 32'h3400, 1'b1);
    wr(3'd0, 32'h300);
    wait_end("R3 rearm finish");
    rd(3'd1, v); chk(v == 32'h7, "R3 rearm accepted", v, 32'h7);
    wr(3'd2, 32'hFF);

    // R8 start flag clear in second descriptor
    add_desc(32'h400, 32'h410, 1, 1, 2, 2, 1, 4, 32'h3600, 1'b1);
    add_desc(32'h410, 0, 1, 1, 2, 2, 0, 4, 32'h3700, 1'b0);
    wr(3'd0, 32'h400);
    wait_end("R8 error end");
    rd(3'd1, v); chk(v == 32'h8, "R8 status error", v, 32'h8);
    rd(3'd2, v); chk(v == 32'h02, "R8 start-flag interrupt", v, 32'h02);
    chk(exp_idx.size() == 0, "R8 first descriptor only", exp_idx.size(), 0);

    // R3 nonzero write while not READY is ignored
    n0 = nreq;
    wr(3'd0, 32'h400);
    repeat (30) @(negedge clk);
    rd(3'd1, v); chk(v == 32'h8, "R3 ignored arm status", v, 32'h8);
    chk(nreq == n0, "R3 ignored arm no reads", nreq, n0);

    // R9 bad rectangles
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFF);
    add_desc(32'h500, 0, 9, 0, 8, 0, 1, 1, 32'h3800, 1'b0);
    wr(3'd0, 32'h500);
    wait_end("R9 x order end");
    rd(3'd1, v); chk(v == 32'h8, "R9 x1<x0 status", v, 32'h8);
    rd(3'd2, v); chk(v == 32'h04, "R9 x1<x0 interrupt", v, 32'h04);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFF);
    add_desc(32'h510, 0, 0, 120, 0, 130, 1, 1, 32'h3900, 1'b0);
    wr(3'd0, 32'h510);
    wait_end("R9 row range end");
    rd(3'd1, v); chk(v == 32'h8, "R9 y1 too large status", v, 32'h8);
    rd(3'd2, v); chk(v == 32'h04, "R9 y1 too large interrupt", v, 32'h04);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFF);
    add_desc(32'h520, 0, 0, 5, 0, 4, 1, 1, 32'h3A00, 1'b0);
    wr(3'd0, 32'h520);
    wait_end("R9 y order end");
    rd(3'd2, v); chk(v == 32'h04, "R9 y1<y0 interrupt", v, 32'h04);

    // R2 abort in the middle of a walk
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFF);
    add_desc(32'h600, 0, 0, 0, 15, 3, 1, 9, 32'h4000, 1'b1);
    ws0 = wr_seen;
    wr(3'd0, 32'h600);
    repeat (40) @(negedge clk);
    wr(3'd0, 32'h0);
    exp_idx.delete(); exp_dat.delete(); exp_sel.delete();
    rd(3'd1, v); chk(v == 32'h1, "R2 abort status", v, 32'h1);
    repeat (60) @(negedge clk);
    chk(wr_seen - ws0 > 0 && wr_seen - ws0 < 64, "R2 abort cut walk", wr_seen - ws0, 32);
    rd(3'd2, v); chk(v == 32'h0, "R2 no completion after abort", v, 32'h0);

    // R5 R6 fresh chain after abort
    add_desc(32'h700, 32'h710, 30, 30, 32, 32, 1, 6, 32'h5000, 1'b1);
    add_desc(32'h710, 0, 7, 100, 7, 101, 1, 12, 32'h5100, 1'b1);
    wr(3'd0, 32'h700);
    wait_end("R6 post-abort finish");
    rd(3'd1, v); chk(v == 32'h7, "R6 post-abort status", v, 32'h7);
    chk(exp_idx.size() == 0, "R5 post-abort entries", exp_idx.size(), 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule